// File: doc/BRIEF.md
# On-Demand Slot Request Generator

This block sits in the output-sample path of an audio codec that runs on a fixed 48 kHz frame. Once per frame it decides, for each stereo pair of output slots, whether the controller should send a fresh sample in the next output frame. It then raises the active-low request flags that travel back in the input frame. The decision comes from a per-pair sample-rate value and a variable-rate enable. When variable rate is off, every slot asks for data in every frame. When it is on, a phase accumulator per pair paces the requests so that their long-run rate matches the programmed rate in hertz.

At the start of the following frame, the block samples the tag bits of the incoming output frame. If a pair was asked for data and either of its tags is absent, it raises a one-cycle missing-data pulse for that pair. Serial framing, slot shifting and sample buffering are handled by neighbouring logic. That logic supplies the frame strobe and the tags, and it consumes the flags.

Top module: `slot_req_gen`

## Requirements
- R1: After synchronous reset, every `slot_req_n` bit is 1 (no request), `miss_err` is 0 and every accumulator is zero.
- R2: `slot_req_n` changes only on the clock edge where `frame_strobe` is 1. Between strobes it holds, whatever `tag_in` and the rate inputs do.
- R3: With `vra_en` = 0, every strobe drives all `slot_req_n` bits to 0, and the accumulators are held at zero.
- R4: With `vra_en` = 1, each strobe adds the pair's effective rate to its accumulator. When the sum is at least 48000, the pair requests and 48000 is subtracted. Otherwise the pair does not request and the sum is kept.
- R5: Pair p owns bits 2p (left) and 2p+1 (right) of both `slot_req_n` and `tag_in`, and its two request bits always carry the same value.
- R6: The accumulator of a pair returns to zero when its rate value differs from the previous cycle's value, or when `vra_en` goes from 0 to 1. The next addition then starts from zero.
- R7: A rate above 48000 counts as 48000, so the pair requests on every strobe. A rate of 0 never requests.
- R8: At a strobe, if pair p was requesting during the frame that is ending and `tag_in[2p]` or `tag_in[2p+1]` is 0, then `miss_err[p]` is 1 for exactly the one cycle after that edge.
- R9: Tags of a pair that was not requesting raise no error.
- R10: Starting from a cleared accumulator at constant rate r, the number of requests over n strobes is floor(n*r/48000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | One-cycle pulse at the start of each output frame |
| vra_en | input | 1 | Variable-rate enable |
| rate_val | input | NUM_PAIRS*RATE_W | Per-pair sample rate in Hz, pair p at bits [p*RATE_W +: RATE_W] |
| tag_in | input | 2*NUM_PAIRS | Valid tags of the output frame now starting, valid with the strobe |
| slot_req_n | output | 2*NUM_PAIRS | Active-low per-slot request flags |
| miss_err | output | NUM_PAIRS | One-cycle pulse per pair when requested data did not arrive |

## Verification
The bench targets the remainder carried across frames. A design that resets the accumulator on every hit instead of subtracting 48000 gives the wrong request count at 44.1 kHz and 11.025 kHz. It also targets the clear on a rate change: a missing clear lets an old phase produce an early request. Rates above the frame rate are covered, because an unclamped sum overflows the accumulator's range. Tag checking is covered as well. A design that compares tags against the decision being made now, instead of the one made a frame earlier, flags the wrong frames. A design that checks only one tag of a pair misses a lone absent tag.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

    localparam int unsigned DEF_RATE_W   = 16;
    localparam int unsigned DEF_FRAME_HZ = 48000;
    localparam int unsigned DEF_PAIRS    = 2;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // bit index of one side of a slot pair in the flag and tag vectors
    function automatic int unsigned slot_bit(input int unsigned pair, input side_e side);
        return 2 * pair + ((side == SIDE_R) ? 1 : 0);
    endfunction

    // rates faster than the frame rate are capped at one sample per frame
    function automatic logic [31:0] sat_rate(input logic [31:0] rate, input logic [31:0] limit);
        return (rate > limit) ? limit : rate;
    endfunction

    typedef struct packed {
        logic req;
        logic clr;
    } pace_ctl_t;

endpackage

// File: rtl/sreq_pacer.sv
module sreq_pacer
    import sreq_pkg::*;
#(
    parameter int unsigned RATE_W   = DEF_RATE_W,
    parameter int unsigned FRAME_HZ = DEF_FRAME_HZ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              vra_en,
    input  logic [RATE_W-1:0] rate,
    output logic              req
);

    localparam int unsigned ACC_W = $clog2(2 * FRAME_HZ);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(FRAME_HZ);

    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  base;
    logic [ACC_W-1:0]  eff;
    logic [ACC_W-1:0]  sum;
    logic [ACC_W-1:0]  next_acc;
    logic [RATE_W-1:0] rate_q;
    logic              vra_q;
    logic              hit;
    pace_ctl_t         ctl;

    always_comb begin
        ctl.clr  = vra_en && (!vra_q || (rate != rate_q));
        base     = ctl.clr ? '0 : acc;
        eff      = ACC_W'(sat_rate(32'(rate), 32'(FRAME_HZ)));
        sum      = base + eff;
        hit      = (sum >= LIMIT);
        next_acc = hit ? (sum - LIMIT) : sum;
        ctl.req  = !vra_en || hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            rate_q <= '0;
            vra_q  <= 1'b0;
            req    <= 1'b0;
        end else begin
            rate_q <= rate;
            vra_q  <= vra_en;
            if (!vra_en)
                acc <= '0;
            else if (strobe)
                acc <= next_acc;
            else if (ctl.clr)
                acc <= '0;
            if (strobe)
                req <= ctl.req;
        end
    end

endmodule

// File: rtl/sreq_tagcheck.sv
module sreq_tagcheck (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic pending,
    input  logic tag_l,
    input  logic tag_r,
    output logic err
);

    logic absent;

    always_comb absent = !(tag_l && tag_r);

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else
            err <= strobe && pending && absent;
    end

endmodule

// File: rtl/slot_req_gen.sv
module slot_req_gen
    import sreq_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = DEF_PAIRS,
    parameter int unsigned RATE_W    = DEF_RATE_W,
    parameter int unsigned FRAME_HZ  = DEF_FRAME_HZ
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_strobe,
    input  logic                          vra_en,
    input  logic [NUM_PAIRS*RATE_W-1:0]   rate_val,
    input  logic [2*NUM_PAIRS-1:0]        tag_in,
    output logic [2*NUM_PAIRS-1:0]        slot_req_n,
    output logic [NUM_PAIRS-1:0]          miss_err
);

    localparam int unsigned SLOTS = 2 * NUM_PAIRS;

    logic [NUM_PAIRS-1:0] pair_req;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int unsigned BL = slot_bit(p, SIDE_L);
        localparam int unsigned BR = slot_bit(p, SIDE_R);

        sreq_pacer #(
            .RATE_W   (RATE_W),
            .FRAME_HZ (FRAME_HZ)
        ) i_pacer (
            .clk    (clk),
            .rst    (rst),
            .strobe (frame_strobe),
            .vra_en (vra_en),
            .rate   (rate_val[p*RATE_W +: RATE_W]),
            .req    (pair_req[p])
        );

        // the held decision is the request of the frame now ending
        sreq_tagcheck i_tagchk (
            .clk     (clk),
            .rst     (rst),
            .strobe  (frame_strobe),
            .pending (pair_req[p]),
            .tag_l   (tag_in[BL]),
            .tag_r   (tag_in[BR]),
            .err     (miss_err[p])
        );

        assign slot_req_n[BL] = !pair_req[p];
        assign slot_req_n[BR] = !pair_req[p];
    end

    if (SLOTS != 2 * NUM_PAIRS) begin : g_bad
        initial $error("slot count mismatch");
    end

endmodule

// File: rtl/slot_req_gen_chk.sv
module slot_req_gen_chk #(
    parameter int unsigned NUM_PAIRS = 2,
    parameter int unsigned RATE_W    = 16,
    parameter int unsigned FRAME_HZ  = 48000
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        frame_strobe,
    input logic                        vra_en,
    input logic [NUM_PAIRS*RATE_W-1:0] rate_val,
    input logic [2*NUM_PAIRS-1:0]      slot_req_n,
    input logic [NUM_PAIRS-1:0]        miss_err
);

    // R1: reset leaves no request and no error
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (&slot_req_n) && (miss_err == '0));

    // R2: flags hold between strobes
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_strobe |=> $stable(slot_req_n));

    // R3: fixed-rate mode requests everything
    p_all_req_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && !vra_en) |=> (slot_req_n == '0));

    // R8: an error pulse only follows a strobe
    p_err_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (|miss_err) |-> $past(frame_strobe));

    // R9: nothing pending means no error
    p_no_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && (&slot_req_n)) |=> (miss_err == '0));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pchk
        // R5: both sides of a pair agree
        p_pair_same_r5: assert property (@(posedge clk) disable iff (rst)
            slot_req_n[2*p] == slot_req_n[2*p+1]);

        // R7: saturated rate requests every frame
        p_full_rate_r7: assert property (@(posedge clk) disable iff (rst)
            (frame_strobe && vra_en &&
             (32'(rate_val[p*RATE_W +: RATE_W]) >= FRAME_HZ)) |=> !slot_req_n[2*p]);

        // R7: zero rate never requests
        p_zero_rate_r7: assert property (@(posedge clk) disable iff (rst)
            (frame_strobe && vra_en && (rate_val[p*RATE_W +: RATE_W] == '0))
            |=> slot_req_n[2*p]);
    end

endmodule

bind slot_req_gen slot_req_gen_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .RATE_W    (RATE_W),
    .FRAME_HZ  (FRAME_HZ)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_strobe (frame_strobe),
    .vra_en       (vra_en),
    .rate_val     (rate_val),
    .slot_req_n   (slot_req_n),
    .miss_err     (miss_err)
);

// File: tb/test_slot_req_gen.sv
`timescale 1ns/1ps
module test_slot_req_gen;

    localparam int NP = 2;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_strobe = 1'b0;
    logic          vra_en = 1'b0;
    logic [2*RW-1:0] rate_val = '0;
    logic [3:0]    tag_in = '0;
    logic [3:0]    slot_req_n;
    logic [1:0]    miss_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    slot_req_gen #(.NUM_PAIRS(NP), .RATE_W(RW), .FRAME_HZ(48000)) i_slot_req_gen (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .vra_en(vra_en),
        .rate_val(rate_val), .tag_in(tag_in), .slot_req_n(slot_req_n), .miss_err(miss_err)
    );

    typedef struct packed {
        logic        vra;
        logic [15:0] r0;
        logic [15:0] r1;
        logic [3:0]  tags;
        logic [3:0]  exp_req;
        logic [1:0]  exp_err;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd48000, 16'd48000, 4'b0000, 4'b0000, 2'b00},
        '{1'b0, 16'd48000, 16'd48000, 4'b1111, 4'b0000, 2'b00},
        '{1'b0, 16'd48000, 16'd48000, 4'b0111, 4'b0000, 2'b10},
        '{1'b1, 16'd24000, 16'd16000, 4'b1111, 4'b1111, 2'b00},
        '{1'b1, 16'd24000, 16'd16000, 4'b0000, 4'b1100, 2'b00},
        '{1'b1, 16'd24000, 16'd16000, 4'b0000, 4'b0011, 2'b01},
        '{1'b1, 16'd24000, 16'd16000, 4'b1100, 4'b1100, 2'b00},
        '{1'b1, 16'd24000, 16'd16000, 4'b0111, 4'b1111, 2'b00},
        '{1'b1, 16'd44100, 16'd8000,  4'b0000, 4'b1111, 2'b00},
        '{1'b1, 16'd44100, 16'd8000,  4'b0000, 4'b1100, 2'b00},
        '{1'b1, 16'd44100, 16'd8000,  4'b0010, 4'b1100, 2'b01},
        '{1'b1, 16'd50000, 16'd0,     4'b0011, 4'b1100, 2'b00},
        '{1'b0, 16'd50000, 16'd0,     4'b0000, 4'b0000, 2'b01}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic v, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        vra_en   = v;
        rate_val = {b, a};
        @(negedge clk);
    endtask

    // one strobe; returns sampled one edge later
    task automatic frame(input logic [3:0] tags);
        @(negedge clk);
        tag_in       = tags;
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, c1;
        logic [3:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset flags", 32'(slot_req_n), 32'hF);
        check("R1 reset err", 32'(miss_err), 32'h0);

        // vector table: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            set_cfg(VECS[i].vra, VECS[i].r0, VECS[i].r1);
            frame(VECS[i].tags);
            check($sformatf("R4/R3/R6/R7 vec%0d flags", i), 32'(slot_req_n), 32'(VECS[i].exp_req));
            check($sformatf("R8/R9 vec%0d err", i), 32'(miss_err), 32'(VECS[i].exp_err));
        end

        // R8: error lasts exactly one cycle
        @(negedge clk);
        check("R8 err pulse width", 32'(miss_err), 32'h0);

        // R2: hold between strobes while tags and rate move
        held = slot_req_n;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            tag_in   = 4'(k);
            rate_val = {16'(k * 7), 16'(k * 3)};
        end
        check("R2 flags held", 32'(slot_req_n), 32'(held));
        check("R2 no err between strobes", 32'(miss_err), 32'h0);

        // R1: reset in the middle of activity
        set_cfg(1'b0, 16'd48000, 16'd48000);
        frame(4'b1111);
        do_reset();
        check("R1 mid-run reset flags", 32'(slot_req_n), 32'hF);
        frame(4'b0000);
        check("R1 pending cleared by reset R9", 32'(miss_err), 32'h0);

        // R6: rate change discards accumulated phase
        do_reset();
        set_cfg(1'b1, 16'd32000, 16'd32000);
        frame(4'b1111);
        set_cfg(1'b1, 16'd24000, 16'd32000);
        frame(4'b1111);
        check("R6 pair0 cleared, no request", 32'(slot_req_n[1:0]), 32'h3);
        check("R6 pair1 kept phase, requests", 32'(slot_req_n[3:2]), 32'h0);

        // R7: rate zero never requests, tags ignored R9
        set_cfg(1'b1, 16'd0, 16'd0);
        frame(4'b1111);
        frame(4'b0000);
        check("R7 zero rate", 32'(slot_req_n), 32'hF);
        check("R9 ignored tags", 32'(miss_err), 32'h0);

        // R10: long-run pacing
        do_reset();
        set_cfg(1'b1, 16'd44100, 16'd11025);
        c0 = 0;
        c1 = 0;
        for (int f = 0; f < 100; f++) begin
            frame(4'b1111);
            if (!slot_req_n[0]) c0++;
            if (!slot_req_n[2]) c1++;
            if (slot_req_n[0] !== slot_req_n[1] || slot_req_n[2] !== slot_req_n[3]) begin
                errors++;
                $display("FAIL R5 pair split actual=%0h expected=pairs equal", slot_req_n);
            end
            if (miss_err !== 2'b00) begin
                errors++;
                $display("FAIL R8 spurious err actual=%0h expected=0", miss_err);
            end
        end
        checks += 2;
        check("R10 count at 44100", 32'(c0), 32'd91);
        check("R10 count at 11025", 32'(c1), 32'd22);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule